// File: doc/BRIEF.md
# Per-Processor Masked Device Interrupt Router

This block gathers a 64-bit vector of level-sensitive device interrupt lines into a raw request register. It keeps a separate 64-bit enable mask for each of up to four processors. Each processor's interrupt output is registered, and it is high when at least one raw request is enabled in that processor's mask. A cascaded legacy interrupt controller has its own input, and that input feeds one fixed raw request bit.

Software reaches the registers through a 32-bit register port. Each 64-bit register takes two accesses that share one 32-bit holding latch. A write to the low half only fills the latch. A write to the high half commits the 64-bit value, with the written word as the upper half and the latch as the lower half. A read of the low half returns the lower word and loads the upper word into the latch. A read of the high half returns the latch.

Top module: `irq_router`

## Requirements
- R1: After synchronous reset, every mask, the raw request register, the half-access latch and all `cpu_irq` outputs are zero.
- R2: Raw request bit n (n other than 55) takes the level of `irq_lines[n]` one clock after that level is sampled. The raw register reads at offset 0x300.
- R3: Raw request bit 55 follows `legacy_irq` with the same one-clock delay, and `irq_lines[55]` has no effect on it.
- R4: `cpu_irq[i]` is the OR-reduction of mask i AND the raw requests. It is registered, so it follows a mask commit by one clock and an input line change by two clocks.
- R5: Masks for processors 0 to 3 are at offsets 0x200, 0x240, 0x600 and 0x640. Read-only masked views are at 0x280, 0x2C0, 0x680 and 0x6C0. Each view returns mask i AND the raw requests.
- R6: Address bit 2 selects the half: 0 is the low half and 1 is the high half. A write to a low half only loads the latch and leaves every mask unchanged. A write to a mask's high half commits {written data, latch}.
- R7: A read of a low half returns bits 31:0 and loads bits 63:32 into the latch. A read of any mapped high half returns the latch. The one latch is shared by all registers.
- R8: Writes to the raw request register and to the masked views change no state other than the latch.
- R9: An access to an unmapped offset raises `reg_err` in the cycle of the access. A read of such an offset returns 0xFFFFFFFF. The access changes no mask and leaves the latch unchanged. With no access in progress, `reg_err` is 0 and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 64 | Level-sensitive device interrupt lines |
| legacy_irq | input | 1 | Cascaded legacy controller output, feeds raw bit 55 |
| reg_addr | input | 12 | Register byte offset; bit 2 selects the high half |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| reg_err | output | 1 | Unmapped-offset strobe, valid in the cycle of the access |
| cpu_irq | output | NUM_CPUS | Registered per-processor interrupt outputs |

## Verification
The assertions check on every cycle that each `cpu_irq` bit matches the previous cycle's mask AND raw product, and that raw bits 0 and 55 track their inputs. They also check that a low-half write never disturbs a mask, that an unmapped read returns all ones, and that the port stays quiet when idle. The bench's scenarios cover everything that depends on an access sequence: the order in which the two halves commit, the latch shared between reads and writes, writes to read-only registers being dropped, and the latch surviving unmapped accesses. The bench also runs full bit sweeps of the raw register and of each processor's mask against alternating line patterns.

// File: rtl/irq_router_pkg.sv
`timescale 1ns/1ps
package irq_router_pkg;
    localparam int REG_W    = 64;
    localparam int HALF_W   = REG_W / 2;
    localparam int ADDR_W   = 12;
    localparam int MAX_CPUS = 4;
    localparam logic [ADDR_W-1:0] RAW_OFS = 12'h300;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_MASK,
        SEL_VIEW,
        SEL_RAW
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] cpu;
        logic       hi;
    } reg_sel_t;

    // Offset of a processor's mask: the pairs sit in two banks, bit 6 picks the odd one.
    function automatic logic [ADDR_W-1:0] mask_ofs(input logic [1:0] cpu);
        logic [ADDR_W-1:0] o;
        o    = cpu[1] ? 12'h600 : 12'h200;
        o[6] = cpu[0];
        return o;
    endfunction

    function automatic logic [ADDR_W-1:0] view_ofs(input logic [1:0] cpu);
        return mask_ofs(cpu) | 12'h080;
    endfunction

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] addr, input int ncpus);
        reg_sel_t          s;
        logic [ADDR_W-1:0] base;
        base   = addr & ~ADDR_W'(7);
        s.kind = SEL_NONE;
        s.cpu  = '0;
        s.hi   = addr[2];
        if (base == RAW_OFS) s.kind = SEL_RAW;
        for (int c = 0; c < MAX_CPUS; c++) begin
            if (c < ncpus) begin
                if (base == mask_ofs(2'(c))) begin
                    s.kind = SEL_MASK;
                    s.cpu  = 2'(c);
                end else if (base == view_ofs(2'(c))) begin
                    s.kind = SEL_VIEW;
                    s.cpu  = 2'(c);
                end
            end
        end
        return s;
    endfunction
endpackage

// File: rtl/irq_raw_capture.sv
`timescale 1ns/1ps
module irq_raw_capture import irq_router_pkg::*; #(
    parameter int LEGACY_LINE = 55
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] lines,
    input  logic             legacy,
    output logic [REG_W-1:0] raw_q
);
    logic [REG_W-1:0] raw_d;

    always_comb begin
        raw_d              = lines;
        raw_d[LEGACY_LINE] = legacy;
    end

    always_ff @(posedge clk) begin
        if (rst) raw_q <= '0;
        else     raw_q <= raw_d;
    end
endmodule

// File: rtl/irq_mask_bank.sv
`timescale 1ns/1ps
module irq_mask_bank import irq_router_pkg::*; #(
    parameter int NUM_CPUS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_CPUS-1:0]       wr_en,
    input  logic [REG_W-1:0]          wr_data,
    input  logic [REG_W-1:0]          raw,
    output logic [NUM_CPUS*REG_W-1:0] mask_flat,
    output logic [NUM_CPUS*REG_W-1:0] view_flat,
    output logic [NUM_CPUS-1:0]       cpu_irq
);
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        logic [REG_W-1:0] mask_q;
        logic [REG_W-1:0] view;

        always_ff @(posedge clk) begin
            if (rst)           mask_q <= '0;
            else if (wr_en[c]) mask_q <= wr_data;
        end

        assign view = mask_q & raw;

        always_ff @(posedge clk) begin
            if (rst) cpu_irq[c] <= 1'b0;
            else     cpu_irq[c] <= |view;
        end

        assign mask_flat[c*REG_W +: REG_W] = mask_q;
        assign view_flat[c*REG_W +: REG_W] = view;
    end
endmodule

// File: rtl/irq_reg_port.sv
`timescale 1ns/1ps
module irq_reg_port import irq_router_pkg::*; #(
    parameter int NUM_CPUS = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr,
    input  logic                      rd,
    input  logic [HALF_W-1:0]         wdata,
    input  logic [NUM_CPUS*REG_W-1:0] mask_flat,
    input  logic [NUM_CPUS*REG_W-1:0] view_flat,
    input  logic [REG_W-1:0]          raw,
    output logic [HALF_W-1:0]         rdata,
    output logic                      err,
    output logic [NUM_CPUS-1:0]       mask_wr_en,
    output logic [REG_W-1:0]          commit_data
);
    reg_sel_t          sel;
    logic [REG_W-1:0]  value;
    logic [HALF_W-1:0] latch_q;
    logic              mapped;
    logic              rd_only;

    assign sel     = decode_addr(addr, NUM_CPUS);
    assign mapped  = (sel.kind != SEL_NONE);
    assign rd_only = rd && !wr;

    always_comb begin
        value = '0;
        case (sel.kind)
            SEL_RAW: value = raw;
            SEL_MASK, SEL_VIEW: begin
                for (int c = 0; c < NUM_CPUS; c++) begin
                    if (sel.cpu == 2'(c))
                        value = (sel.kind == SEL_MASK) ? mask_flat[c*REG_W +: REG_W]
                                                       : view_flat[c*REG_W +: REG_W];
                end
            end
            default: value = '0;
        endcase
    end

    assign err = (rd || wr) && !mapped;

    always_comb begin
        rdata = '0;
        if (rd_only) begin
            if (!mapped)     rdata = '1;
            else if (sel.hi) rdata = latch_q;
            else             rdata = value[HALF_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= '0;
        else if (wr && mapped && !sel.hi)
            latch_q <= wdata;
        else if (rd_only && mapped && !sel.hi)
            latch_q <= value[REG_W-1:HALF_W];
    end

    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++)
            mask_wr_en[c] = wr && sel.hi && (sel.kind == SEL_MASK) && (sel.cpu == 2'(c));
    end

    assign commit_data = {wdata, latch_q};
endmodule

// File: rtl/irq_router.sv
`timescale 1ns/1ps
module irq_router import irq_router_pkg::*; #(
    parameter int NUM_CPUS    = 4,
    parameter int LEGACY_LINE = 55
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [REG_W-1:0]    irq_lines,
    input  logic                legacy_irq,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [HALF_W-1:0]   reg_wdata,
    output logic [HALF_W-1:0]   reg_rdata,
    output logic                reg_err,
    output logic [NUM_CPUS-1:0] cpu_irq
);
    logic [REG_W-1:0]          raw_q;
    logic [NUM_CPUS*REG_W-1:0] mask_flat;
    logic [NUM_CPUS*REG_W-1:0] view_flat;
    logic [NUM_CPUS-1:0]       mask_wr_en;
    logic [REG_W-1:0]          commit_data;

    irq_raw_capture #(.LEGACY_LINE(LEGACY_LINE)) u_raw (
        .clk    (clk),
        .rst    (rst),
        .lines  (irq_lines),
        .legacy (legacy_irq),
        .raw_q  (raw_q)
    );

    irq_mask_bank #(.NUM_CPUS(NUM_CPUS)) u_masks (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (mask_wr_en),
        .wr_data   (commit_data),
        .raw       (raw_q),
        .mask_flat (mask_flat),
        .view_flat (view_flat),
        .cpu_irq   (cpu_irq)
    );

    irq_reg_port #(.NUM_CPUS(NUM_CPUS)) u_port (
        .clk         (clk),
        .rst         (rst),
        .addr        (reg_addr),
        .wr          (reg_wr),
        .rd          (reg_rd),
        .wdata       (reg_wdata),
        .mask_flat   (mask_flat),
        .view_flat   (view_flat),
        .raw         (raw_q),
        .rdata       (reg_rdata),
        .err         (reg_err),
        .mask_wr_en  (mask_wr_en),
        .commit_data (commit_data)
    );
endmodule

// File: rtl/irq_router_chk.sv
`timescale 1ns/1ps
module irq_router_chk import irq_router_pkg::*; #(
    parameter int NUM_CPUS    = 4,
    parameter int LEGACY_LINE = 55
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      line0,
    input logic                      legacy_irq,
    input logic                      reg_hi,
    input logic                      reg_wr,
    input logic                      reg_rd,
    input logic [HALF_W-1:0]         reg_rdata,
    input logic                      reg_err,
    input logic [NUM_CPUS-1:0]       cpu_irq,
    input logic [NUM_CPUS*REG_W-1:0] mask_flat,
    input logic [REG_W-1:0]          raw_q
);
    logic [NUM_CPUS-1:0] exp_irq;

    always_comb begin
        for (int c = 0; c < NUM_CPUS; c++)
            exp_irq[c] = |(mask_flat[c*REG_W +: REG_W] & raw_q);
    end

    // R4: each output is last cycle's mask AND raw product
    p_irq_follows_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cpu_irq == $past(exp_irq)));

    // R2: an ordinary line lands in the raw register one clock later
    p_line_level_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (raw_q[0] == $past(line0)));

    // R3: the legacy input owns its raw bit
    p_legacy_bit_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (raw_q[LEGACY_LINE] == $past(legacy_irq)));

    // R6: a low-half write commits nothing
    p_low_write_no_commit_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && !reg_hi) |=> $stable(mask_flat));

    // R9: unmapped reads return all ones
    p_err_all_ones_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_err) |-> (reg_rdata == '1));

    // R9: idle port is quiet
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd || reg_wr) |-> (!reg_err && reg_rdata == '0));
endmodule

bind irq_router irq_router_chk #(.NUM_CPUS(NUM_CPUS), .LEGACY_LINE(LEGACY_LINE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .line0      (irq_lines[0]),
    .legacy_irq (legacy_irq),
    .reg_hi     (reg_addr[2]),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .reg_err    (reg_err),
    .cpu_irq    (cpu_irq),
    .mask_flat  (mask_flat),
    .raw_q      (raw_q)
);

// File: tb/irq_router_test.sv
`timescale 1ns/1ps
module irq_router_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] irq_lines = '0;
    logic        legacy_irq = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err;
    logic [3:0]  cpu_irq;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;

    irq_router uut (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .legacy_irq(legacy_irq),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_err(reg_err), .cpu_irq(cpu_irq)
    );

    function automatic logic [11:0] mask_addr(input int c);
        case (c)
            0: return 12'h200;
            1: return 12'h240;
            2: return 12'h600;
            default: return 12'h640;
        endcase
    endfunction

    function automatic logic [11:0] view_addr(input int c);
        return mask_addr(c) | 12'h080;
    endfunction

    function automatic logic [63:0] exp_raw(input logic [63:0] l, input logic leg);
        logic [63:0] r;
        r = l;
        r[55] = leg;
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        #5 e = reg_err;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd32(input logic [11:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #5 d = reg_rdata; e = reg_err;
        @(posedge clk);
        #1 reg_rd = 1'b0;
    endtask

    task automatic wr64(input logic [11:0] a, input logic [63:0] v);
        logic e;
        wr32(a, v[31:0], e);
        wr32(a | 12'h004, v[63:32], e);
    endtask

    task automatic rd64(input logic [11:0] a, output logic [63:0] v);
        logic [31:0] lo, hi;
        logic e;
        rd32(a, lo, e);
        rd32(a | 12'h004, hi, e);
        v = {hi, lo};
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 200000);
        miscompares++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [63:0] v, pat, m;
        logic [31:0] d;
        logic e;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        check("R1 cpu_irq", {60'b0, cpu_irq}, 64'h0);
        rd32(12'h304, d, e);
        check("R1 latch", {32'b0, d}, 64'h0);
        rd64(12'h300, v);
        check("R1 raw", v, 64'h0);
        for (int c = 0; c < 4; c++) begin
            rd64(mask_addr(c), v);
            check("R1 mask", v, 64'h0);
        end

        // R2/R3: single-bit sweep of the raw register
        for (int b = 0; b < 64; b++) begin
            irq_lines = 64'h1 << b;
            settle();
            rd64(12'h300, v);
            check(b == 55 ? "R3 line55 ignored" : "R2 raw bit", v, exp_raw(64'h1 << b, 1'b0));
        end
        irq_lines = '0; legacy_irq = 1'b1;
        settle();
        rd64(12'h300, v);
        check("R3 legacy sets bit55", v, 64'h0080_0000_0000_0000);
        irq_lines = '1; legacy_irq = 1'b0;
        settle();
        rd64(12'h300, v);
        check("R3 legacy clears bit55", v, 64'hFF7F_FFFF_FFFF_FFFF);

        // R4: latency from an input line
        irq_lines = '0;
        wr64(mask_addr(0), 64'h1);
        settle();
        check("R4 idle", {60'b0, cpu_irq}, 64'h0);
        irq_lines = 64'h1;
        @(posedge clk); #1;
        check("R4 one clock after line", {60'b0, cpu_irq}, 64'h0);
        @(posedge clk); #1;
        check("R4 two clocks after line", {60'b0, cpu_irq}, 64'h1);
        irq_lines = '0;
        settle();
        check("R4 line dropped", {60'b0, cpu_irq}, 64'h0);
        wr64(mask_addr(0), 64'h0);

        // R4/R5/R6: per-processor mask bit sweep
        for (int c = 0; c < 4; c++) begin
            pat = (c % 2 == 1) ? 64'hAAAA_AAAA_AAAA_AAAA : 64'h5555_5555_5555_5555;
            irq_lines = pat;
            for (int b = 0; b < 64; b++) begin
                m = 64'h1 << b;
                wr64(mask_addr(c), m);
                settle();
                check("R4 sweep irq", {60'b0, cpu_irq},
                      {60'b0, 4'((|(m & exp_raw(pat, 1'b0))) ? (1 << c) : 0)});
                rd64(view_addr(c), v);
                check("R5 view", v, m & exp_raw(pat, 1'b0));
                rd64(mask_addr(c), v);
                check("R6 mask readback", v, m);
            end
            wr64(mask_addr(c), 64'h0);
        end

        // R4: several processors at once
        wr64(mask_addr(0), '1);
        wr64(mask_addr(1), 64'h0);
        wr64(mask_addr(2), 64'h0080_0000_0000_0000);
        wr64(mask_addr(3), 64'h8000_0000_0000_0001);
        irq_lines = 64'h1; legacy_irq = 1'b1;
        settle();
        check("R4 multi", {60'b0, cpu_irq}, 64'hD);
        irq_lines = 64'h0; legacy_irq = 1'b0;
        settle();
        check("R4 multi clear", {60'b0, cpu_irq}, 64'h0);

        // R6: low-half write alone commits nothing, high half commits {data, latch}
        wr32(mask_addr(1), 32'hCAFEF00D, e);
        rd64(mask_addr(1), v);
        check("R6 low write only latches", v, 64'h0);
        wr32(mask_addr(1), 32'hCAFEF00D, e);
        wr32(mask_addr(1) | 12'h004, 32'h1234_5678, e);
        rd64(mask_addr(1), v);
        check("R6 commit", v, 64'h1234_5678_CAFE_F00D);

        // R7: read halves and shared latch
        rd32(mask_addr(1), d, e);
        check("R7 low read", {32'b0, d}, 64'hCAFE_F00D);
        rd32(mask_addr(2) | 12'h004, d, e);
        check("R7 shared latch", {32'b0, d}, 64'h1234_5678);

        // R8: writes to read-only registers ignored
        irq_lines = 64'hF0;
        settle();
        wr64(12'h300, '1);
        wr64(view_addr(0), 64'h0);
        wr64(view_addr(2), '1);
        rd64(12'h300, v);
        check("R8 raw unchanged", v, 64'hF0);
        rd64(mask_addr(0), v);
        check("R8 mask0 unchanged", v, '1);
        rd64(mask_addr(2), v);
        check("R8 mask2 unchanged", v, 64'h0080_0000_0000_0000);
        check("R8 cpu_irq", {60'b0, cpu_irq}, 64'h1);

        // R9: unmapped offsets
        rd32(12'h208, d, e);
        check("R9 unmapped read", {31'b0, e, d}, {31'b0, 1'b1, 32'hFFFF_FFFF});
        rd32(mask_addr(1), d, e);
        check("R9 mapped read no err", {63'b0, e}, 64'h0);
        rd32(12'h100, d, e);
        check("R9 unmapped low read err", {63'b0, e}, 64'h1);
        wr32(12'h100, 32'hAAAA_5555, e);
        check("R9 unmapped low write err", {63'b0, e}, 64'h1);
        wr32(12'h344, 32'h0BAD_0BAD, e);
        check("R9 unmapped high write err", {63'b0, e}, 64'h1);
        rd32(12'h604, d, e);
        check("R9 latch kept", {32'b0, d}, 64'h1234_5678);
        rd64(mask_addr(1), v);
        check("R9 mask kept", v, 64'h1234_5678_CAFE_F00D);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule